// File: doc/BRIEF.md
# Polled Peripheral Bus Device Port

This block is the peripheral side of a polled, strobe-driven parallel bus. The host broadcasts an 8-bit device address and pulses an address strobe. The port compares the address against a parameterised set of unit addresses. It then remembers which unit, if any, won. That choice persists until the next address strobe, whatever happens on the address lines in between. The value 0x00 is the reserved "nobody" address and never selects anything.

While a unit is selected, output-bus bytes carried by the output strobe, and optionally by the auxiliary control strobe, are captured into a one-cycle write pulse for the device core. The address lines are sampled at that moment as a qualifier: when address bits 7 and 5 (zero-based) are both set, the byte is marked as a restart command. A short ready/valid input port takes 9-bit words from the core. Bit 8 of a word marks a special code. The port places each word on the input bus, holds it for one setup clock, and then pulses the input strobe. Every line the device may pull (ready/busy, input data, input strobe) is modelled as a drive enable plus a value, and every enable stays low unless a unit is selected.

Top module: `bus_dev_port`

## Requirements
- R1: After reset, `sel` is 0, `sel_unit` is 0, `wr_valid` is 0 and every drive enable (`rb_oe`, `ib_oe`, `ibs_oe`) is 0.
- R2: On the first clock where `abs_stb` is high after being low, an address equal to a unit address sets `sel` on the following cycle. Selection persists while `ab` changes, until the next rising `abs_stb`.
- R3: A rising `abs_stb` with an address matching no unit clears `sel`. Address 0x00 never matches, even if a unit is configured with it.
- R4: With several unit addresses, `sel_unit` gives the index of the matching unit (the lowest index if two are equal), and 0 when nothing is selected.
- R5: A rising `obs_stb` while selected gives a one-cycle `wr_valid` on the next cycle, with `wr_data` equal to `ob` at the edge, `wr_ctrl` 0 and `wr_unit` equal to `sel_unit`. When not selected, nothing is produced.
- R6: A rising `cbs_stb` while selected gives the same pulse with `wr_ctrl` 1 only when `CTRL_EN` is 1. Otherwise it has no effect on `wr_valid`.
- R7: `rb_oe` equals `sel` and `rb_val` is `dev_ready` while selected. `ib_oe` and `ibs_oe` are never set while not selected.
- R8: An accepted 9-bit input word appears unchanged on `ib_val[8:0]`, with `ib_oe` all ones, until its strobe ends. Bit 8 is carried like the rest.
- R9: `wr_restart` is 1 exactly when `ab[7]` and `ab[5]` were both 1 at the strobe edge that produced `wr_valid`.
- R10: When `FIX_B5` is 1, input line index 4 is enabled and asserted for as long as a unit is selected, even with no transfer in progress.
- R11: `rd_ready` is 1 only while selected and idle. An accepted word is followed by one setup cycle, then `ibs_val` and `ibs_oe` high for exactly `STB_LEN` cycles, then idle.
- R12: A deselection during an input transfer drops all drivers at once, and the transfer is abandoned rather than resumed on reselection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ab | input | 8 | Broadcast address / qualifier lines |
| abs_stb | input | 1 | Address strobe, active high |
| ob | input | 8 | Output data bus |
| obs_stb | input | 1 | Output strobe, active high |
| cbs_stb | input | 1 | Auxiliary control strobe, active high |
| sel | output | 1 | A unit of this port is selected |
| sel_unit | output | UW | Index of the selected unit |
| wr_valid | output | 1 | One-cycle write pulse to the core |
| wr_data | output | 8 | Byte latched at the strobe |
| wr_ctrl | output | 1 | Pulse came from the control strobe |
| wr_restart | output | 1 | Restart qualifier seen on the address lines |
| wr_unit | output | UW | Unit targeted by the write |
| dev_ready | input | 1 | Core ready to take a byte |
| rb_oe | output | 1 | Ready/busy drive enable |
| rb_val | output | 1 | Ready/busy value (1 = ready) |
| rd_valid | input | 1 | Core offers an input word |
| rd_data | input | 9 | Input word, bit 8 = special code |
| rd_ready | output | 1 | Port accepts the offered word |
| ib_oe | output | 9 | Input bus drive enables |
| ib_val | output | 9 | Input bus values (1 = asserted) |
| ibs_oe | output | 1 | Input strobe drive enable |
| ibs_val | output | 1 | Input strobe value |

## Verification
The bench builds two copies on one shared stimulus, and both have three unit addresses, one of them 0x00. Because of that configured zero address, the reserved-address rule and the unit index encoding can be reached. The first copy has the control strobe enabled, the bit-4 capability hold on, and a four-cycle input strobe. The second has the control strobe disabled, no hold, and a two-cycle strobe. This pairing lets one stimulus show both the presence and the absence of the control-strobe write and the capability line, and lets it show how the strobe length follows its parameter.

// File: rtl/bus_dev_port.sv
module bus_dev_port #(
  parameter int NUM_UNITS = 2,
  parameter logic [NUM_UNITS*8-1:0] UNIT_ADDRS = 16'h2105,
  parameter bit CTRL_EN = 1'b1,
  parameter bit FIX_B5 = 1'b0,
  parameter int STB_LEN = 3,
  localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ab,
  input  logic          abs_stb,
  input  logic [7:0]    ob,
  input  logic          obs_stb,
  input  logic          cbs_stb,
  output logic          sel,
  output logic [UW-1:0] sel_unit,
  output logic          wr_valid,
  output logic [7:0]    wr_data,
  output logic          wr_ctrl,
  output logic          wr_restart,
  output logic [UW-1:0] wr_unit,
  input  logic          dev_ready,
  output logic          rb_oe,
  output logic          rb_val,
  input  logic          rd_valid,
  input  logic [8:0]    rd_data,
  output logic          rd_ready,
  output logic [8:0]    ib_oe,
  output logic [8:0]    ib_val,
  output logic          ibs_oe,
  output logic          ibs_val
);
  localparam int CW = (STB_LEN > 1) ? $clog2(STB_LEN) : 1;
  localparam logic [8:0] B5_MASK = FIX_B5 ? 9'h010 : 9'h000;

  typedef enum logic [1:0] {IDLE, SETUP, PULSE} phase_t;

  logic [NUM_UNITS-1:0] hit;
  logic                 any_hit;
  logic [UW-1:0]        hit_idx;
  logic                 abs_q, obs_q, cbs_q;
  logic                 abs_rise, obs_rise, cbs_rise;
  phase_t               phase;
  logic [CW-1:0]        cnt;
  logic [8:0]           hold;
  logic                 busy;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_cmp
    assign hit[i] = (ab != 8'h00) && (ab == UNIT_ADDRS[i*8 +: 8]);
  end

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        hit_idx = UW'(i);
      end
    end
  end

  assign abs_rise = abs_stb && !abs_q;
  assign obs_rise = obs_stb && !obs_q;
  assign cbs_rise = CTRL_EN && cbs_stb && !cbs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abs_q <= 1'b0;
      obs_q <= 1'b0;
      cbs_q <= 1'b0;
      sel <= 1'b0;
      sel_unit <= '0;
      wr_valid <= 1'b0;
      wr_data <= '0;
      wr_ctrl <= 1'b0;
      wr_restart <= 1'b0;
      wr_unit <= '0;
    end else begin
      abs_q <= abs_stb;
      obs_q <= obs_stb;
      cbs_q <= cbs_stb;
      if (abs_rise) begin
        sel <= any_hit;
        sel_unit <= any_hit ? hit_idx : '0;
      end
      wr_valid <= sel && (obs_rise || cbs_rise);
      if (sel && (obs_rise || cbs_rise)) begin
        wr_data <= ob;
        wr_ctrl <= !obs_rise;
        wr_restart <= ab[7] && ab[5];
        wr_unit <= sel_unit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt <= '0;
      hold <= '0;
    end else if (!sel) begin
      phase <= IDLE;
      cnt <= '0;
    end else begin
      case (phase)
        IDLE: if (rd_valid) begin
          hold <= rd_data;
          phase <= SETUP;
        end
        SETUP: begin
          phase <= PULSE;
          cnt <= '0;
        end
        PULSE: if (cnt == CW'(STB_LEN - 1)) phase <= IDLE;
               else cnt <= cnt + 1'b1;
        default: phase <= IDLE;
      endcase
    end
  end

  assign busy     = sel && (phase != IDLE);
  assign rd_ready = sel && (phase == IDLE);
  assign rb_oe    = sel;
  assign rb_val   = sel && dev_ready;
  assign ib_oe    = (busy ? 9'h1FF : 9'h000) | (sel ? B5_MASK : 9'h000);
  assign ib_val   = (busy ? hold : 9'h000) | (sel ? B5_MASK : 9'h000);
  assign ibs_oe   = sel && (phase == PULSE);
  assign ibs_val  = ibs_oe;
endmodule

module bus_dev_port_chk #(
  parameter bit CTRL_EN = 1'b1,
  parameter int UW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    ab,
  input logic          abs_stb,
  input logic          sel,
  input logic [UW-1:0] sel_unit,
  input logic          wr_valid,
  input logic          wr_ctrl,
  input logic          wr_restart,
  input logic          rb_oe,
  input logic [8:0]    ib_oe,
  input logic [8:0]    ib_val,
  input logic          ibs_oe,
  input logic          ibs_val
);
  logic abs_seen;
  always_ff @(posedge clk) abs_seen <= rst_n ? abs_stb : 1'b0;

  assert_no_drive_unsel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!rb_oe && !ibs_oe && ib_oe == 9'h000));

  assert_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_stb && !abs_seen && ab == 8'h00) |=> !sel);

  assert_sel_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !(abs_stb && !abs_seen)) |=> (sel && $stable(sel_unit)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_ctrl_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !CTRL_EN) |-> !wr_ctrl);

  assert_restart_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_restart == ($past(ab[7]) && $past(ab[5]))));

  assert_setup_before_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibs_val) |-> ($stable(ib_val) && $past(ib_oe[0])));
endmodule

bind bus_dev_port bus_dev_port_chk #(.CTRL_EN(CTRL_EN), .UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ab(ab), .abs_stb(abs_stb), .sel(sel),
  .sel_unit(sel_unit), .wr_valid(wr_valid), .wr_ctrl(wr_ctrl),
  .wr_restart(wr_restart), .rb_oe(rb_oe), .ib_oe(ib_oe), .ib_val(ib_val),
  .ibs_oe(ibs_oe), .ibs_val(ibs_val)
);

// File: tb/ref_dev.sv
module ref_dev #(
  parameter int N = 3,
  parameter logic [N*8-1:0] ADDRS = 24'h002105,
  parameter bit CTRL_EN = 1'b1,
  parameter bit FIX_B5 = 1'b0,
  parameter int STB_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ab,
  input  logic       abs_stb,
  input  logic [7:0] ob,
  input  logic       obs_stb,
  input  logic       cbs_stb,
  input  logic       dev_ready,
  input  logic       rd_valid,
  input  logic [8:0] rd_data,
  output int         e_sel,
  output int         e_unit,
  output int         e_wv,
  output int         e_wdata,
  output int         e_wctrl,
  output int         e_wrst,
  output int         e_wunit,
  output int         e_rb_oe,
  output int         e_rb_val,
  output int         e_rd_ready,
  output int         e_ib_oe,
  output int         e_ib_val,
  output int         e_ibs
);
  int m_sel = 0, m_unit = 0, step = 0, left = 0, word = 0;
  int p_abs = 0, p_obs = 0, p_cbs = 0;
  int wv = 0, wd = 0, wc = 0, wr = 0, wu = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_unit = 0; step = 0; left = 0;
      p_abs = 0; p_obs = 0; p_cbs = 0; wv = 0; wd = 0; wc = 0; wr = 0; wu = 0;
    end else begin
      int o_rise, c_rise;
      o_rise = (obs_stb && !p_obs) ? 1 : 0;
      c_rise = (CTRL_EN && cbs_stb && !p_cbs) ? 1 : 0;
      if (m_sel == 0) step = 0;
      else if (step == 0) begin
        if (rd_valid) begin word = rd_data; step = 1; end
      end else if (step == 1) begin step = 2; left = STB_LEN; end
      else begin
        left = left - 1;
        if (left == 0) step = 0;
      end
      wv = (m_sel != 0 && (o_rise != 0 || c_rise != 0)) ? 1 : 0;
      if (wv != 0) begin
        wd = ob; wc = (o_rise != 0) ? 0 : 1;
        wr = (ab >= 8'hA0 && (ab & 8'h20) != 0 && (ab & 8'h80) != 0) ? 1 : 0;
        wu = m_unit;
      end
      if (abs_stb && !p_abs) begin
        m_sel = 0; m_unit = 0;
        if (ab != 0)
          for (int i = N - 1; i >= 0; i--)
            if (ADDRS[i*8 +: 8] == ab) begin m_sel = 1; m_unit = i; end
      end
      p_abs = abs_stb; p_obs = obs_stb; p_cbs = cbs_stb;
    end
  end

  always @* begin
    int capb;
    capb = (FIX_B5 && m_sel != 0) ? 16 : 0;
    e_sel = m_sel; e_unit = m_unit;
    e_wv = wv; e_wdata = wd; e_wctrl = wc; e_wrst = wr; e_wunit = wu;
    e_rb_oe = m_sel;
    e_rb_val = (m_sel != 0 && dev_ready) ? 1 : 0;
    e_rd_ready = (m_sel != 0 && step == 0) ? 1 : 0;
    e_ib_oe = ((m_sel != 0 && step != 0) ? 511 : 0) | capb;
    e_ib_val = ((m_sel != 0 && step != 0) ? word : 0) | capb;
    e_ibs = (m_sel != 0 && step == 2) ? 1 : 0;
  end
endmodule

// File: tb/test_bus_dev_port.sv
module test_bus_dev_port;
  localparam int CLK_PER = 10;
  localparam int UWB = 2;
  localparam logic [23:0] ADDRS = 24'h002105;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ab = '0, ob = '0;
  logic abs_stb = 0, obs_stb = 0, cbs_stb = 0, dev_ready = 0, rd_valid = 0;
  logic [8:0] rd_data = '0;

  logic a_sel, a_wv, a_wc, a_wr, a_rbo, a_rbv, a_rdy, a_ibso, a_ibsv;
  logic [UWB-1:0] a_unit, a_wu;
  logic [7:0] a_wd;
  logic [8:0] a_ibo, a_ibv;
  logic b_sel, b_wv, b_wc, b_wr, b_rbo, b_rbv, b_rdy, b_ibso, b_ibsv;
  logic [UWB-1:0] b_unit, b_wu;
  logic [7:0] b_wd;
  logic [8:0] b_ibo, b_ibv;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  bus_dev_port #(.NUM_UNITS(3), .UNIT_ADDRS(ADDRS), .CTRL_EN(1), .FIX_B5(1), .STB_LEN(4)) i_bus_dev_port (
    .clk(clk), .rst_n(rst_n), .ab(ab), .abs_stb(abs_stb), .ob(ob), .obs_stb(obs_stb), .cbs_stb(cbs_stb),
    .sel(a_sel), .sel_unit(a_unit), .wr_valid(a_wv), .wr_data(a_wd), .wr_ctrl(a_wc), .wr_restart(a_wr),
    .wr_unit(a_wu), .dev_ready(dev_ready), .rb_oe(a_rbo), .rb_val(a_rbv), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(a_rdy), .ib_oe(a_ibo), .ib_val(a_ibv), .ibs_oe(a_ibso), .ibs_val(a_ibsv));

  bus_dev_port #(.NUM_UNITS(3), .UNIT_ADDRS(ADDRS), .CTRL_EN(0), .FIX_B5(0), .STB_LEN(2)) i_bus_dev_port_b (
    .clk(clk), .rst_n(rst_n), .ab(ab), .abs_stb(abs_stb), .ob(ob), .obs_stb(obs_stb), .cbs_stb(cbs_stb),
    .sel(b_sel), .sel_unit(b_unit), .wr_valid(b_wv), .wr_data(b_wd), .wr_ctrl(b_wc), .wr_restart(b_wr),
    .wr_unit(b_wu), .dev_ready(dev_ready), .rb_oe(b_rbo), .rb_val(b_rbv), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(b_rdy), .ib_oe(b_ibo), .ib_val(b_ibv), .ibs_oe(b_ibso), .ibs_val(b_ibsv));

  int ea[13], eb[13];
  ref_dev #(.N(3), .ADDRS(ADDRS), .CTRL_EN(1), .FIX_B5(1), .STB_LEN(4)) m_a (
    .clk(clk), .rst_n(rst_n), .ab(ab), .abs_stb(abs_stb), .ob(ob), .obs_stb(obs_stb), .cbs_stb(cbs_stb),
    .dev_ready(dev_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .e_sel(ea[0]), .e_unit(ea[1]), .e_wv(ea[2]), .e_wdata(ea[3]), .e_wctrl(ea[4]), .e_wrst(ea[5]),
    .e_wunit(ea[6]), .e_rb_oe(ea[7]), .e_rb_val(ea[8]), .e_rd_ready(ea[9]), .e_ib_oe(ea[10]),
    .e_ib_val(ea[11]), .e_ibs(ea[12]));
  ref_dev #(.N(3), .ADDRS(ADDRS), .CTRL_EN(0), .FIX_B5(0), .STB_LEN(2)) m_b (
    .clk(clk), .rst_n(rst_n), .ab(ab), .abs_stb(abs_stb), .ob(ob), .obs_stb(obs_stb), .cbs_stb(cbs_stb),
    .dev_ready(dev_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .e_sel(eb[0]), .e_unit(eb[1]), .e_wv(eb[2]), .e_wdata(eb[3]), .e_wctrl(eb[4]), .e_wrst(eb[5]),
    .e_wunit(eb[6]), .e_rb_oe(eb[7]), .e_rb_val(eb[8]), .e_rd_ready(eb[9]), .e_ib_oe(eb[10]),
    .e_ib_val(eb[11]), .e_ibs(eb[12]));

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cmp_a();
    chk("R2", "a.sel", a_sel, ea[0]);
    chk("R4", "a.sel_unit", a_unit, ea[1]);
    chk("R5", "a.wr_valid", a_wv, ea[2]);
    if (ea[2] != 0) begin
      chk("R5", "a.wr_data", a_wd, ea[3]);
      chk("R6", "a.wr_ctrl", a_wc, ea[4]);
      chk("R9", "a.wr_restart", a_wr, ea[5]);
      chk("R4", "a.wr_unit", a_wu, ea[6]);
    end
    chk("R7", "a.rb_oe", a_rbo, ea[7]);
    chk("R7", "a.rb_val", a_rbv, ea[8]);
    chk("R11", "a.rd_ready", a_rdy, ea[9]);
    chk("R10", "a.ib_oe", a_ibo, ea[10]);
    chk("R8", "a.ib_val", a_ibv, ea[11]);
    chk("R11", "a.ibs_val", a_ibsv, ea[12]);
    chk("R7", "a.ibs_oe", a_ibso, ea[12]);
  endtask

  task automatic cmp_b();
    chk("R2", "b.sel", b_sel, eb[0]);
    chk("R4", "b.sel_unit", b_unit, eb[1]);
    chk("R6", "b.wr_valid", b_wv, eb[2]);
    if (eb[2] != 0) begin
      chk("R5", "b.wr_data", b_wd, eb[3]);
      chk("R9", "b.wr_restart", b_wr, eb[5]);
    end
    chk("R7", "b.rb_val", b_rbv, eb[8]);
    chk("R11", "b.rd_ready", b_rdy, eb[9]);
    chk("R10", "b.ib_oe", b_ibo, eb[10]);
    chk("R8", "b.ib_val", b_ibv, eb[11]);
    chk("R11", "b.ibs_val", b_ibsv, eb[12]);
  endtask

  always @(posedge clk) begin
    cycles++;
    #(CLK_PER/4);
    if (rst_n && !done) begin
      cmp_a();
      cmp_b();
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic addr_strobe(logic [7:0] a);
    @(negedge clk); ab = a; abs_stb = 1;
    @(negedge clk); ab = 8'h33;
    @(negedge clk); abs_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic out_strobe(logic [7:0] a, logic [7:0] d, bit ctl);
    @(negedge clk); ab = a; ob = d;
    if (ctl) cbs_stb = 1; else obs_stb = 1;
    @(negedge clk);
    @(negedge clk); obs_stb = 0; cbs_stb = 0; ob = 8'hFF; ab = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic offer(logic [8:0] w, int tail);
    @(negedge clk); rd_valid = 1; rd_data = w;
    for (int k = 0; k < 50 && !a_rdy; k++) @(negedge clk);
    @(negedge clk); rd_valid = 0; rd_data = 9'h0AA;
    repeat (tail) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "a.sel reset", a_sel, 0);
    chk("R1", "a.drivers reset", {a_rbo, a_ibso, a_ibo}, 0);
    chk("R1", "b.wr_valid reset", b_wv, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    out_strobe(8'hA0, 8'h11, 0);
    addr_strobe(8'h05);
    chk("R2", "sel after address change", a_sel, 1);
    dev_ready = 1;
    out_strobe(8'h11, 8'h5A, 0);
    out_strobe(8'hA0, 8'hC3, 0);
    out_strobe(8'h80, 8'h3C, 0);
    out_strobe(8'h22, 8'h77, 1);
    dev_ready = 0;
    repeat (2) @(negedge clk);
    chk("R10", "a cap line idle", a_ibo, 9'h010);
    offer(9'h1A5, 8);
    addr_strobe(8'h21);
    chk("R4", "a.sel_unit for second address", a_unit, 1);
    offer(9'h0F0, 8);
    out_strobe(8'hE5, 8'h96, 0);
    addr_strobe(8'h00);
    chk("R3", "zero address deselects", a_sel, 0);
    out_strobe(8'h11, 8'h44, 0);
    @(negedge clk); rd_valid = 1; rd_data = 9'h155;
    repeat (4) @(negedge clk);
    chk("R7", "no enables while unselected", {a_rdy, a_ibo, b_ibo}, 0);
    rd_valid = 0;
    addr_strobe(8'h21);
    offer(9'h13C, 1);
    addr_strobe(8'h44);
    chk("R12", "drivers off after deselect", {a_ibso, a_ibo}, 0);
    addr_strobe(8'h21);
    chk("R12", "idle after reselect", a_rdy, 1);
    addr_strobe(8'h05);
    dev_ready = 1;
    offer(9'h003, 8);
    out_strobe(8'hA5, 8'h01, 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule